// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three identical 16-bit down-counting timer channels behind one byte-wide register port. Each channel counts on a shared count-clock enable (`tick`). It shapes its own output line in one of six modes: a level that rises once at terminal count, a level that falls once at terminal count, a one-tick rate pulse, a square wave, and a single-tick strobe started either by software or by the gate. Each channel has its own gate input. Depending on the mode, the gate either suspends counting or restarts it on a rising edge.

Software writes a control byte to address 3. That byte picks a channel, an access order (low byte, high byte, or low then high), a counting mode and binary or BCD counting. Count values are written and read at the channel's own address (0, 1 or 2). A count of zero means the largest period: 65536 in binary and 10000 in BCD. A counter-latch command freezes the current count for readback. A read-back command can latch the count, the status byte, or both, for any set of channels at once.

Top module: `pit_timer_top`

## Requirements
- R1: After reset every channel is in mode 3, low-then-high access, binary, with an effective count of 65536 (read back as 0x0000) and its output high. The status byte is therefore 0xB6.
- R2: A write to address 3 is a control byte, decoded as follows:
  - bits 7:6 select the channel, and the value 3 means a read-back command;
  - bits 5:4 give the access order: 00 is a counter latch, 01 low byte only, 10 high byte only, 11 low then high;
  - bits 3:1 give the mode, with 6 and 7 read as 2 and 3;
  - bit 0 selects BCD.

  Addresses 0 to 2 are the channel data ports. The status byte is laid out as: bit 7 output level, bit 6 zero, bits 5:4 access order, bits 3:1 mode, bit 0 BCD.
- R3: Mode 0: the output is low from the load until the count has elapsed, then high. It stays high until the next control byte.
- R4: Mode 1: the output is high from the load until the count has elapsed, then low. A gate rising edge reloads the count and drives the output high again.
- R5: Mode 2: the output is high for exactly one tick each time a nonzero multiple of the count has elapsed, and the counter reloads at that point.
- R6: Mode 3: within each period of N ticks the output is high for the first (N+1)/2 ticks and low for the rest.
- R7: Modes 4 and 5: the output is high only for the one tick at which exactly N ticks have elapsed, and it never changes again until the next load. In mode 5 a gate rising edge restarts the count.
- R8: A written count of 0 becomes 65536 in binary and 10000 in BCD. In BCD mode, counts are written and read as four BCD digits. The live count never exceeds the effective count.
- R9: In low-only access one byte loads the count and a read returns the low byte. In high-only access one byte loads bits 15:8 and a read returns the high byte. In low-then-high access the load happens on the second byte, and reads alternate low then high.
- R10: A counter latch captures the count as it stood before any tick in the same cycle. The latched value stays frozen until it has been fully read, and further latch commands are ignored meanwhile.
- R11: A read-back command sets mask bits 1, 2 and 3 for channels 0, 1 and 2. Bit 4 = 0 latches status and bit 5 = 0 latches the count. A latched status is returned before a latched count.
- R12: In modes 0, 2, 3 and 4 a low gate holds the count unchanged while ticks arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register port |
| rd_en | input | 1 | Read strobe; advances read sequencing |
| addr | input | 2 | 0 to 2 channel data, 3 control byte |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte for the addressed channel |
| tick | input | 1 | Count-clock enable shared by all channels |
| gate | input | 3 | Gate input per channel |
| tout | output | 3 | Output line per channel |

## Verification
A counter-latch command can land in the same clock as a count tick. In that cycle the decrement and the capture contend for the same count. The bench provokes this by issuing the latch byte with `tick` held high in the same cycle, on a freshly loaded rate-pulse channel. It judges the result by reading the latched bytes, which must hold the count as loaded, and then latching again, which must show one tick taken.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam int NUM_CH = 3;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 16;
    localparam int EXT_W  = CNT_W + 1;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_LOHI  = 2'b11
    } acc_e;

    typedef struct packed {
        logic        ctl_we;
        acc_e        acc;
        logic [2:0]  mode;
        logic        bcd;
        logic        cnt_latch;
        logic        sts_latch;
        logic        data_we;
    } chan_cmd_s;

    function automatic logic [EXT_W-1:0] bcd_to_bin(input logic [CNT_W-1:0] b);
        return EXT_W'(b[15:12]) * EXT_W'(1000) + EXT_W'(b[11:8]) * EXT_W'(100)
             + EXT_W'(b[7:4]) * EXT_W'(10) + EXT_W'(b[3:0]);
    endfunction

    function automatic logic [CNT_W-1:0] bin_to_bcd(input logic [EXT_W-1:0] v);
        logic [EXT_W-1:0] r;
        r = v % EXT_W'(10000);
        return {4'(r / EXT_W'(1000)), 4'((r / EXT_W'(100)) % EXT_W'(10)),
                4'((r / EXT_W'(10)) % EXT_W'(10)), 4'(r % EXT_W'(10))};
    endfunction
endpackage

// File: rtl/pit_ctl_decode.sv
module pit_ctl_decode
    import pit_pkg::*;
(
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output chan_cmd_s         cmd [NUM_CH]
);
    logic [2:0] mode_fix;

    always_comb begin
        mode_fix = wdata[3:1];
        if (mode_fix[1]) mode_fix[2] = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            cmd[i]         = '0;
            cmd[i].acc     = acc_e'(wdata[5:4]);
            cmd[i].mode    = mode_fix;
            cmd[i].bcd     = wdata[0];
            cmd[i].data_we = wr_en && (addr == 2'(i));
            if (wr_en && addr == 2'd3) begin
                if (wdata[7:6] == 2'(i)) begin
                    if (wdata[5:4] == ACC_LATCH) cmd[i].cnt_latch = 1'b1;
                    else                         cmd[i].ctl_we    = 1'b1;
                end else if (wdata[7:6] == 2'd3 && wdata[1+i]) begin
                    cmd[i].cnt_latch = !wdata[5];
                    cmd[i].sts_latch = !wdata[4];
                end
            end
        end
    end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              gate,
    input  chan_cmd_s         cmd,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rdata,
    output logic              out
);
    typedef struct packed {
        logic [2:0]        mode;
        acc_e              acc;
        logic              bcd;
        logic [EXT_W-1:0]  cnt;
        logic [EXT_W-1:0]  n;
        logic              run;
        logic              out;
        logic              wr_hi;
        logic [BYTE_W-1:0] wpend;
        logic              rd_hi;
        logic [CNT_W-1:0]  latch;
        logic              cl;
        logic              sl;
        logic [BYTE_W-1:0] status;
        logic              gate_q;
    } chan_s;

    chan_s s_d, s_q;

    logic [CNT_W-1:0] live_cnt, src_cnt, full_cnt;
    logic [EXT_W-1:0] nxt_cnt, load_val;
    logic [EXT_W:0]   half;
    logic             gate_ok, hw_mode, do_load;

    always_comb begin
        s_d      = s_q;
        s_d.gate_q = gate;
        live_cnt = s_q.bcd ? bin_to_bcd(s_q.cnt) : s_q.cnt[CNT_W-1:0];
        src_cnt  = s_q.cl ? s_q.latch : live_cnt;
        half     = ({1'b0, s_q.n} + (EXT_W+1)'(1)) >> 1;
        hw_mode  = (s_q.mode == 3'd1) || (s_q.mode == 3'd5);
        gate_ok  = hw_mode || gate;
        nxt_cnt  = (s_q.cnt == EXT_W'(1)) ? s_q.n : s_q.cnt - EXT_W'(1);

        if (s_q.sl)                rdata = s_q.status;
        else if (s_q.acc == ACC_LO) rdata = src_cnt[7:0];
        else if (s_q.acc == ACC_HI) rdata = src_cnt[15:8];
        else                        rdata = s_q.rd_hi ? src_cnt[15:8] : src_cnt[7:0];

        // counting step
        if (tick && s_q.run && gate_ok) begin
            unique case (s_q.mode)
                3'd0: if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - EXT_W'(1);
                    if (s_q.cnt == EXT_W'(1)) s_d.out = 1'b1;
                end
                3'd1: if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - EXT_W'(1);
                    if (s_q.cnt == EXT_W'(1)) s_d.out = 1'b0;
                end
                3'd2: begin
                    s_d.cnt = nxt_cnt;
                    s_d.out = (s_q.cnt == EXT_W'(1));
                end
                3'd3: begin
                    s_d.cnt = nxt_cnt;
                    s_d.out = ({1'b0, s_q.n - nxt_cnt} < half);
                end
                default: begin
                    if (s_q.cnt == EXT_W'(1)) begin
                        s_d.cnt = '0;
                        s_d.out = 1'b1;
                    end else if (s_q.cnt == '0) begin
                        s_d.out = 1'b0;
                    end else begin
                        s_d.cnt = s_q.cnt - EXT_W'(1);
                    end
                end
            endcase
        end

        // gate rising edge restarts the hardware-triggered modes
        if (hw_mode && s_q.run && gate && !s_q.gate_q) begin
            s_d.cnt = s_q.n;
            s_d.out = (s_q.mode == 3'd1);
        end

        // read sequencing
        if (rd_en) begin
            if (s_q.sl) begin
                s_d.sl = 1'b0;
            end else if (s_q.acc == ACC_LOHI) begin
                s_d.rd_hi = !s_q.rd_hi;
                if (s_q.rd_hi) s_d.cl = 1'b0;
            end else begin
                s_d.cl = 1'b0;
            end
        end

        // latch commands (capture pre-tick state)
        if (cmd.cnt_latch && !s_q.cl) begin
            s_d.latch = live_cnt;
            s_d.cl    = 1'b1;
        end
        if (cmd.sts_latch && !s_q.sl) begin
            s_d.status = {s_q.out, 1'b0, s_q.acc, s_q.mode, s_q.bcd};
            s_d.sl     = 1'b1;
        end

        // data writes
        do_load  = 1'b0;
        full_cnt = '0;
        if (cmd.data_we) begin
            unique case (s_q.acc)
                ACC_LO: begin full_cnt = {8'h00, wbyte}; do_load = 1'b1; end
                ACC_HI: begin full_cnt = {wbyte, 8'h00}; do_load = 1'b1; end
                default: begin
                    if (!s_q.wr_hi) begin
                        s_d.wpend = wbyte;
                        s_d.wr_hi = 1'b1;
                    end else begin
                        full_cnt  = {wbyte, s_q.wpend};
                        s_d.wr_hi = 1'b0;
                        do_load   = 1'b1;
                    end
                end
            endcase
        end
        load_val = s_q.bcd ? bcd_to_bin(full_cnt) : EXT_W'(full_cnt);
        if (load_val == '0) load_val = s_q.bcd ? EXT_W'(10000) : EXT_W'(65536);
        if (do_load) begin
            s_d.n   = load_val;
            s_d.cnt = load_val;
            s_d.run = 1'b1;
            s_d.out = (s_q.mode == 3'd1) || (s_q.mode == 3'd3);
        end

        // control byte
        if (cmd.ctl_we) begin
            s_d.mode  = cmd.mode;
            s_d.acc   = cmd.acc;
            s_d.bcd   = cmd.bcd;
            s_d.run   = 1'b0;
            s_d.out   = 1'b0;
            s_d.wr_hi = 1'b0;
            s_d.rd_hi = 1'b0;
            s_d.cl    = 1'b0;
            s_d.sl    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.mode  <= 3'd3;
            s_q.acc   <= ACC_LOHI;
            s_q.n     <= EXT_W'(65536);
            s_q.cnt   <= EXT_W'(65536);
            s_q.run   <= 1'b1;
            s_q.out   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign out = s_q.out;

    // R3: once high in mode 0 the output stays high until reprogrammed
    p_mode0_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == 3'd0 && s_q.out && !cmd.ctl_we && !cmd.data_we) |=> s_q.out);

    // R5: rate pulse lasts one tick when the period exceeds one
    p_pulse_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == 3'd2 && s_q.out && tick && gate && s_q.n != EXT_W'(1)
         && !cmd.ctl_we && !cmd.data_we) |=> !s_q.out);

    // R12: a low gate freezes the count in the gate-level modes
    p_gate_freeze_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && !gate && s_q.mode != 3'd1 && s_q.mode != 3'd5
         && !cmd.ctl_we && !cmd.data_we) |=> $stable(s_q.cnt));

    // R10: the latch holds until read or reprogrammed
    p_latch_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cl && !rd_en && !cmd.ctl_we) |=> (s_q.cl && $stable(s_q.latch)));

    // R8: the live count never exceeds the effective count
    p_cnt_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= s_q.n);
endmodule

// File: rtl/pit_timer_top.sv
module pit_timer_top
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              tick,
    input  logic [NUM_CH-1:0] gate,
    output logic [NUM_CH-1:0] tout
);
    chan_cmd_s         cmd   [NUM_CH];
    logic [BYTE_W-1:0] ch_rd [NUM_CH];

    pit_ctl_decode u_dec (
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .cmd   (cmd)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        pit_channel u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .gate  (gate[i]),
            .cmd   (cmd[i]),
            .wbyte (wdata),
            .rd_en (rd_en && (addr == 2'(i))),
            .rdata (ch_rd[i]),
            .out   (tout[i])
        );
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (addr == 2'(i)) rdata = ch_rd[i];
    end
endmodule

// File: tb/pit_timer_top_tb_top.sv
module pit_timer_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [2:0] gate = 3'b011;
    logic [2:0] tout;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    pit_timer_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tick(tick), .gate(gate), .tout(tout)
    );

    typedef struct packed {
        logic [2:0]  mode;
        logic [15:0] n;
        logic [7:0]  k;
        logic [15:0] ec;
        logic        eo;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 16'd5, 8'd3, 16'd2, 1'b0},
        '{3'd0, 16'd5, 8'd5, 16'd0, 1'b1},
        '{3'd0, 16'd5, 8'd7, 16'd0, 1'b1},
        '{3'd1, 16'd4, 8'd2, 16'd2, 1'b1},
        '{3'd1, 16'd4, 8'd4, 16'd0, 1'b0},
        '{3'd2, 16'd4, 8'd4, 16'd4, 1'b1},
        '{3'd2, 16'd4, 8'd5, 16'd3, 1'b0},
        '{3'd3, 16'd5, 8'd2, 16'd3, 1'b1},
        '{3'd3, 16'd5, 8'd3, 16'd2, 1'b0},
        '{3'd3, 16'd5, 8'd5, 16'd5, 1'b1},
        '{3'd3, 16'd4, 8'd2, 16'd2, 1'b0},
        '{3'd4, 16'd3, 8'd3, 16'd0, 1'b1},
        '{3'd4, 16'd3, 8'd4, 16'd0, 1'b0},
        '{3'd5, 16'd3, 8'd3, 16'd0, 1'b1}
    };

    function automatic string tag_of(input logic [2:0] m);
        case (m)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(input string t, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", t, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic rdcnt(input logic [1:0] ch, output logic [15:0] v);
        logic [7:0] lo, hi;
        wr(2'd3, {ch, 6'b000000});
        rd(ch, lo);
        rd(ch, hi);
        v = {hi, lo};
    endtask

    task automatic load(input logic [1:0] ch, input logic [15:0] n);
        wr(ch, n[7:0]);
        wr(ch, n[15:8]);
    endtask

    initial begin
        #(8 * 200000);
        errors++; checks++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R2: reset state and status layout
        chk("R1 reset out ch0", 16'(tout[0]), 16'd1);
        wr(2'd3, 8'hE2);
        rd(2'd0, b);
        chk("R1 R2 reset status ch0", 16'(b), 16'h00B6);
        rd(2'd1, b);
        chk("R1 reset live count lo ch1", 16'(b), 16'h0000);
        rd(2'd1, b);
        chk("R1 reset live count hi ch1", 16'(b), 16'h0000);
        ticks(3);
        rdcnt(2'd0, v);
        chk("R1 ch0 counts from 65536", v, 16'hFFFD);
        chk("R6 ch0 square high early", 16'(tout[0]), 16'd1);
        rdcnt(2'd2, v);
        chk("R12 ch2 gate low holds", v, 16'h0000);

        // table of mode vectors on channel 0
        for (int i = 0; i < NV; i++) begin
            wr(2'd3, {2'b00, 2'b11, VEC[i].mode, 1'b0});
            load(2'd0, VEC[i].n);
            ticks(int'(VEC[i].k));
            chk({tag_of(VEC[i].mode), " out"}, 16'(tout[0]), 16'(VEC[i].eo));
            rdcnt(2'd0, v);
            chk({tag_of(VEC[i].mode), " count"}, v, VEC[i].ec);
        end

        // R8: BCD and zero counts
        wr(2'd3, 8'b00_11_000_1);
        load(2'd0, 16'h0000);
        ticks(1);
        rdcnt(2'd0, v);
        chk("R8 bcd zero is 10000", v, 16'h9999);
        load(2'd0, 16'h0025);
        ticks(5);
        rdcnt(2'd0, v);
        chk("R8 bcd count", v, 16'h0020);
        wr(2'd3, 8'b00_11_010_0);
        load(2'd0, 16'h0000);
        ticks(1);
        rdcnt(2'd0, v);
        chk("R8 binary zero is 65536", v, 16'hFFFF);

        // R9: single-byte access orders
        wr(2'd3, 8'b00_01_000_0);
        wr(2'd0, 8'h07);
        ticks(2);
        rd(2'd0, b);
        chk("R9 low-only read", 16'(b), 16'h0005);
        wr(2'd3, 8'b00_10_000_0);
        wr(2'd0, 8'h01);
        rd(2'd0, b);
        chk("R9 high-only read", 16'(b), 16'h0001);
        ticks(1);
        rd(2'd0, b);
        chk("R9 high-only after tick", 16'(b), 16'h0000);

        // R10: latch freezing
        wr(2'd3, 8'b00_11_010_0);
        load(2'd0, 16'd10);
        ticks(2);
        wr(2'd3, 8'h00);
        ticks(3);
        rd(2'd0, b);
        chk("R10 frozen lo", 16'(b), 16'h0008);
        rd(2'd0, b);
        chk("R10 frozen hi", 16'(b), 16'h0000);
        wr(2'd3, 8'h00);
        ticks(1);
        wr(2'd3, 8'h00);
        rd(2'd0, b);
        chk("R10 second latch ignored", 16'(b), 16'h0005);
        rd(2'd0, b);
        wr(2'd3, 8'b00_11_010_0);
        load(2'd0, 16'd10);
        @(negedge clk);
        wr_en = 1'b1; addr = 2'd3; wdata = 8'h00; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        rd(2'd0, b);
        chk("R10 latch with tick pre-tick", 16'(b), 16'h000A);
        rd(2'd0, b);
        rdcnt(2'd0, v);
        chk("R10 tick taken", v, 16'h0009);

        // R11: read-back command
        wr(2'd3, 8'hE2);
        rd(2'd0, b);
        chk("R11 status mode2", 16'(b), 16'h0034);
        wr(2'd3, 8'hC2);
        rd(2'd0, b);
        chk("R11 status first", 16'(b), 16'h0034);
        rd(2'd0, b);
        chk("R11 count lo after status", 16'(b), 16'h0009);
        rd(2'd0, b);
        chk("R11 count hi after status", 16'(b), 16'h0000);

        // R4: gate restart in mode 1 on channel 1
        wr(2'd3, 8'b01_11_001_0);
        load(2'd1, 16'd4);
        ticks(4);
        chk("R4 mode1 ended low", 16'(tout[1]), 16'd0);
        @(negedge clk) gate = 3'b001;
        @(negedge clk) gate = 3'b011;
        @(negedge clk);
        chk("R4 gate edge raises out", 16'(tout[1]), 16'd1);
        rdcnt(2'd1, v);
        chk("R4 gate edge reloads", v, 16'h0004);

        // R12: low gate suspends mode 0
        wr(2'd3, 8'b00_11_000_0);
        load(2'd0, 16'd5);
        gate = 3'b010;
        ticks(3);
        rdcnt(2'd0, v);
        chk("R12 mode0 gate low holds", v, 16'h0005);
        gate = 3'b011;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule